// File: doc/BRIEF.md
# Gate drive current phase sequencer

This block sets the drive strength for the six gates of a three-phase bridge. Each phase has a high-side gate and a low-side gate. When the commanded state of a gate changes, the block asks the analog stage for a strong peak current. It uses the source setting for turn-on and the sink setting for turn-off. The peak lasts for a programmable number of clock cycles. After that the gate drops to a fixed hold level, which keeps it pulled up or pulled down.

A new command edge inside a window cuts that window short and starts a fresh one in the new direction. The mode and current codes respond in the same cycle as the command edge, so the window never adds latency to the PWM path. While a high-side gate is turning on, the low-side gate of the same phase is forced to a strong pulldown. This stops coupling through the low-side MOSFET's gate capacitance from turning it on.

The peak source and peak sink current codes are live inputs. The window-length select is captured once at the start of each transition.

Top module: `gdrv_seq`

## Requirements
- R1: After reset, every gate reports hold-down mode (code 100) with the hold current code, and every peak status bit is 0.
- R2: When a gate's command goes from off to on, its mode is peak source (001) and its current code equals the source-current input, starting in the same cycle as the edge. This lasts L = (sel+1)*BASE cycles, where sel is the 4-bit window select. The gate then goes to hold up (011) with the hold current code.
- R3: When a gate's command goes from on to off, its mode is peak sink (010) with the sink-current input, for L cycles. The gate then goes to hold down (100).
- R4: The window length is taken from the select input in the edge cycle. Changing the select later has no effect on a window already running.
- R5: A command edge during an active window restarts the window at once. The new window has the new direction and a full new length L.
- R6: While the high gate of a phase is in peak source, the low gate of that phase reports strong pulldown (101) with the all-ones current code.
- R7: If both the high and low commands of a phase are 1, both gates are treated as commanded off.
- R8: A change of the source or sink current input during a peak window appears on the current code in the same cycle.
- R9: The peak status bit of a gate is 1 exactly in the cycles where that gate is in its peak window.
- R10: Gate g uses mode_o[3g+2:3g], cur_o[4g+3:4g] and peak_o[g]. For phase p, gate 2p is the high side and gate 2p+1 is the low side. Phases are independent of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_hi_i | input | 3 | High-side command per phase |
| pwm_lo_i | input | 3 | Low-side command per phase |
| src_cur_i | input | 4 | Peak source current code |
| snk_cur_i | input | 4 | Peak sink current code |
| win_sel_i | input | 4 | Window length select, L = (sel+1)*BASE cycles |
| mode_o | output | 18 | Drive-mode code, 3 bits per gate |
| cur_o | output | 24 | Current-setting code, 4 bits per gate |
| peak_o | output | 6 | Per-gate peak window status |

## Verification
The tests use these command patterns:
- A lone high-side turn-on, which checks the source window length, the hold-up level and the low-side strong pulldown. It also checks that the other phases stay untouched.
- A turn-off with a select change in mid-window, which checks that the sink path and the sampling of the select happen only at the edge.
- A low-side pulse shorter than its window, which checks early termination and the restart length.
- A phase with both commands asserted, which checks that both gates fall back to off.

A change of the current input inside a window checks that the live current code follows it in the same cycle.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
  typedef enum logic [2:0] {
    GM_OFF       = 3'b000,
    GM_PK_SRC    = 3'b001,
    GM_PK_SNK    = 3'b010,
    GM_HOLD_UP   = 3'b011,
    GM_HOLD_DN   = 3'b100,
    GM_STRONG_PD = 3'b101
  } gmode_e;
endpackage

// File: rtl/gdrv_win_timer.sv
module gdrv_win_timer #(
  parameter int BASE  = 4,
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             busy_o
);
  localparam int WMAX = (2 ** SEL_W) * BASE;
  localparam int CW   = (WMAX > 2) ? $clog2(WMAX) : 1;

  logic [CW-1:0] rem_q, rem_d;

  // edge cycle counts as the first peak cycle
  always_comb begin
    rem_d = rem_q;
    if (start_i)          rem_d = CW'((int'(sel_i) + 1) * BASE - 1);
    else if (rem_q != '0) rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rem_q <= '0;
    else         rem_q <= rem_d;
  end

  assign busy_o = (rem_q != '0);

  p_countdown_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && rem_q != '0) |=> (rem_q == $past(rem_q) - 1'b1));
endmodule

// File: rtl/gdrv_gate_ctrl.sv
module gdrv_gate_ctrl
  import gdrv_pkg::*;
#(
  parameter int          BASE     = 4,
  parameter int          SEL_W    = 4,
  parameter int          IW       = 4,
  parameter logic [IW-1:0] HOLD_CUR = IW'(2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [IW-1:0]    src_i,
  input  logic [IW-1:0]    snk_i,
  output gmode_e           mode_o,
  output logic [IW-1:0]    cur_o,
  output logic             peak_o
);
  logic cmd_q, edge_w, busy_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= 1'b0;
    else         cmd_q <= cmd_i;
  end

  assign edge_w = cmd_i ^ cmd_q;

  gdrv_win_timer #(.BASE(BASE), .SEL_W(SEL_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(edge_w),
    .sel_i  (sel_i),
    .busy_o (busy_w)
  );

  assign peak_o = edge_w | busy_w;

  always_comb begin
    if (peak_o) begin
      mode_o = cmd_i ? GM_PK_SRC : GM_PK_SNK;
      cur_o  = cmd_i ? src_i : snk_i;
    end else begin
      mode_o = cmd_i ? GM_HOLD_UP : GM_HOLD_DN;
      cur_o  = HOLD_CUR;
    end
  end

  p_end_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(peak_o) |-> (mode_o == GM_HOLD_UP || mode_o == GM_HOLD_DN));
  p_hold_tracks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peak_o |-> ((mode_o == GM_HOLD_UP) == cmd_i));
endmodule

// File: rtl/gdrv_phase.sv
module gdrv_phase
  import gdrv_pkg::*;
#(
  parameter int            BASE     = 4,
  parameter int            SEL_W    = 4,
  parameter int            IW       = 4,
  parameter logic [IW-1:0] HOLD_CUR = IW'(2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hi_i,
  input  logic             lo_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [IW-1:0]    src_i,
  input  logic [IW-1:0]    snk_i,
  output gmode_e           hi_mode_o,
  output logic [IW-1:0]    hi_cur_o,
  output logic             hi_peak_o,
  output gmode_e           lo_mode_o,
  output logic [IW-1:0]    lo_cur_o,
  output logic             lo_peak_o
);
  logic   hi_cmd, lo_cmd;
  gmode_e lo_raw_mode;
  logic [IW-1:0] lo_raw_cur;

  // both asserted resolves to both off
  assign hi_cmd = hi_i & ~lo_i;
  assign lo_cmd = lo_i & ~hi_i;

  gdrv_gate_ctrl #(.BASE(BASE), .SEL_W(SEL_W), .IW(IW), .HOLD_CUR(HOLD_CUR)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(hi_cmd), .sel_i(sel_i),
    .src_i(src_i), .snk_i(snk_i),
    .mode_o(hi_mode_o), .cur_o(hi_cur_o), .peak_o(hi_peak_o)
  );

  gdrv_gate_ctrl #(.BASE(BASE), .SEL_W(SEL_W), .IW(IW), .HOLD_CUR(HOLD_CUR)) u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(lo_cmd), .sel_i(sel_i),
    .src_i(src_i), .snk_i(snk_i),
    .mode_o(lo_raw_mode), .cur_o(lo_raw_cur), .peak_o(lo_peak_o)
  );

  always_comb begin
    if (hi_mode_o == GM_PK_SRC) begin
      lo_mode_o = GM_STRONG_PD;
      lo_cur_o  = '1;
    end else begin
      lo_mode_o = lo_raw_mode;
      lo_cur_o  = lo_raw_cur;
    end
  end

  p_strong_pd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_mode_o == GM_PK_SRC) |-> (lo_mode_o == GM_STRONG_PD));
  p_no_shoot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((hi_mode_o == GM_PK_SRC || hi_mode_o == GM_HOLD_UP) &&
      (lo_mode_o == GM_PK_SRC || lo_mode_o == GM_HOLD_UP)));
endmodule

// File: rtl/gdrv_seq.sv
module gdrv_seq
  import gdrv_pkg::*;
#(
  parameter int            NPH      = 3,
  parameter int            BASE     = 4,
  parameter int            SEL_W    = 4,
  parameter int            IW       = 4,
  parameter logic [IW-1:0] HOLD_CUR = IW'(2)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NPH-1:0]        pwm_hi_i,
  input  logic [NPH-1:0]        pwm_lo_i,
  input  logic [IW-1:0]         src_cur_i,
  input  logic [IW-1:0]         snk_cur_i,
  input  logic [SEL_W-1:0]      win_sel_i,
  output logic [2*NPH*3-1:0]    mode_o,
  output logic [2*NPH*IW-1:0]   cur_o,
  output logic [2*NPH-1:0]      peak_o
);
  localparam int NG = 2 * NPH;

  gmode_e gate_mode [NG];

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    gdrv_phase #(.BASE(BASE), .SEL_W(SEL_W), .IW(IW), .HOLD_CUR(HOLD_CUR)) u_ph (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hi_i     (pwm_hi_i[p]),
      .lo_i     (pwm_lo_i[p]),
      .sel_i    (win_sel_i),
      .src_i    (src_cur_i),
      .snk_i    (snk_cur_i),
      .hi_mode_o(gate_mode[2*p]),
      .hi_cur_o (cur_o[IW*(2*p) +: IW]),
      .hi_peak_o(peak_o[2*p]),
      .lo_mode_o(gate_mode[2*p+1]),
      .lo_cur_o (cur_o[IW*(2*p+1) +: IW]),
      .lo_peak_o(peak_o[2*p+1])
    );
  end

  for (genvar g = 0; g < NG; g++) begin : g_out
    assign mode_o[3*g +: 3] = gate_mode[g];
  end
endmodule

// File: tb/gdrv_seq_tb_top.sv
module gdrv_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int NPH   = 3;
  localparam int NG    = 6;
  localparam int BASE  = 4;
  localparam logic [3:0] HOLD = 4'd2;
  localparam logic [2:0] M_SRC = 3'b001, M_SNK = 3'b010, M_HUP = 3'b011,
                         M_HDN = 3'b100, M_SPD = 3'b101;

  logic clk = 0, rst_n = 0;
  logic [NPH-1:0] pwm_hi = '0, pwm_lo = '0;
  logic [3:0] src = 4'h9, snk = 4'h7, sel = 4'd0;
  logic [NG*3-1:0] mode;
  logic [NG*4-1:0] cur;
  logic [NG-1:0]   peak;

  int cyc = 0, checks = 0, errors = 0;

  typedef struct {
    int cyc; int g; logic [2:0] m; logic [3:0] c; logic p; string r;
  } item_t;
  item_t q[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gdrv_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwm_hi_i(pwm_hi), .pwm_lo_i(pwm_lo),
    .src_cur_i(src), .snk_cur_i(snk), .win_sel_i(sel),
    .mode_o(mode), .cur_o(cur), .peak_o(peak)
  );

  task automatic push(int c, int g, logic [2:0] m, logic [3:0] cv, logic p, string r);
    item_t it;
    it.cyc = c; it.g = g; it.m = m; it.c = cv; it.p = p; it.r = r;
    q.push_back(it);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (it.cyc < cyc) begin
          errors++;
          $display("FAIL %s: item for cycle %0d missed (now %0d)", it.r, it.cyc, cyc);
        end else if (mode[3*it.g +: 3] !== it.m || cur[4*it.g +: 4] !== it.c ||
                     peak[it.g] !== it.p) begin
          errors++;
          $display("FAIL %s: cyc %0d gate %0d mode/cur/peak=%b/%h/%b expected %b/%h/%b",
                   it.r, cyc, it.g, mode[3*it.g +: 3], cur[4*it.g +: 4], peak[it.g],
                   it.m, it.c, it.p);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk); t = cyc;
    for (int g = 0; g < NG; g++) push(t, g, M_HDN, HOLD, 1'b0, "R1");

    // R2 R6 R8 R9 R10: phase 0 high on, L=8
    wait_to(t + 2);
    @(negedge clk); t = cyc;
    sel = 4'd1; pwm_hi[0] = 1'b1;
    push(t, 0, M_SRC, 4'h9, 1'b1, "R2");
    push(t, 1, M_SPD, 4'hF, 1'b0, "R6");
    push(t, 2, M_HDN, HOLD, 1'b0, "R10");
    push(t + 5, 0, M_SRC, 4'hC, 1'b1, "R8");
    push(t + 7, 0, M_SRC, 4'hC, 1'b1, "R9");
    push(t + 7, 1, M_SPD, 4'hF, 1'b0, "R6");
    push(t + 8, 0, M_HUP, HOLD, 1'b0, "R2");
    push(t + 8, 1, M_HDN, HOLD, 1'b0, "R6");
    wait_to(t + 5); src = 4'hC;
    wait_to(t + 10);

    // R3 R4: high off, L=4, select changed mid-window
    @(negedge clk); t = cyc;
    sel = 4'd0; pwm_hi[0] = 1'b0;
    push(t, 0, M_SNK, 4'h7, 1'b1, "R3");
    push(t, 1, M_HDN, HOLD, 1'b0, "R3");
    push(t + 3, 0, M_SNK, 4'h7, 1'b1, "R4");
    push(t + 4, 0, M_HDN, HOLD, 1'b0, "R4");
    wait_to(t + 1); sel = 4'd15;
    wait_to(t + 6);

    // R5: low of phase 1 pulsed shorter than window, L=8
    @(negedge clk); t = cyc;
    sel = 4'd1; pwm_lo[1] = 1'b1;
    push(t, 3, M_SRC, 4'hC, 1'b1, "R5");
    push(t, 2, M_HDN, HOLD, 1'b0, "R10");
    push(t + 2, 3, M_SRC, 4'hC, 1'b1, "R5");
    push(t + 3, 3, M_SNK, 4'h7, 1'b1, "R5");
    push(t + 10, 3, M_SNK, 4'h7, 1'b1, "R5");
    push(t + 11, 3, M_HDN, HOLD, 1'b0, "R5");
    wait_to(t + 3); pwm_lo[1] = 1'b0;
    wait_to(t + 13);

    // R7: phase 2 high on, then both asserted
    @(negedge clk); t = cyc;
    sel = 4'd0; pwm_hi[2] = 1'b1;
    push(t + 5, 4, M_HUP, HOLD, 1'b0, "R7");
    push(t + 6, 4, M_SNK, 4'h7, 1'b1, "R7");
    push(t + 6, 5, M_HDN, HOLD, 1'b0, "R7");
    push(t + 9, 4, M_SNK, 4'h7, 1'b1, "R7");
    push(t + 10, 4, M_HDN, HOLD, 1'b0, "R7");
    push(t + 10, 5, M_HDN, HOLD, 1'b0, "R7");
    wait_to(t + 6); pwm_lo[2] = 1'b1;
    wait_to(t + 12);

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule